// File: doc/BRIEF.md
# Power-Fail Write-Protect SRAM Guard

This block is a synchronous front end for a small byte-wide RAM. It decodes three active-low strobes (chip select, read enable, write enable) into idle, read and write cycles. A read drives stored data and a registered output-enable for a tri-state data bus. A write is captured while chip select and write enable are both low, and the last address and byte seen are stored when the write closes.

Two supply-status flags feed a four-state guard: one says the supply is under the power-fail threshold, the other says it is under the battery-switchover threshold. When the power-fail flag rises, an access already under way gets a grace window of `GRACE_CYC` clocks to finish. After that window, or at once if the switchover flag rises, the block deselects itself. The bus is released, and strobes, address and data are ignored. Once both flags clear, protection holds for a further `RECOV_CYC` clocks before normal service returns.

All pin inputs pass through a two-flop synchronizer, so every action lags its input by a fixed number of clocks.

Top module: `pfw_sram_guard`

## Requirements
- R1: During and right after reset, `rdata_oe` is low, and the guard starts in its operational (unprotected) state.
- R2: With `cs_n`=0, `rd_n`=0, `wr_n`=1 and no protection, `rdata_oe` is 1 and `rdata` holds the byte stored at `addr`, by the third rising edge after the inputs settle.
- R3: A write is open only while `cs_n` and `wr_n` are both 0. It opens at the later of their falling edges and closes at the earlier of their rising edges. The address and byte present in the last open cycle are stored, and nothing applied after the close is stored.
- R4: If a read has the bus enabled, driving `wr_n` low clears `rdata_oe` on the third rising edge.
- R5: After `pf_low` rises, reads stay served for `GRACE_CYC` clocks. `rdata_oe` is still 1 at rising edge 3+`GRACE_CYC` and is 0 from edge 4+`GRACE_CYC`.
- R6: A write already open when `pf_low` rises, and which closes inside the grace window, is stored.
- R7: A write still open when the grace window expires is aborted and stores nothing.
- R8: A write that first opens while the grace window is running is not stored.
- R9: While protected, `rdata_oe` stays 0 and write strobes store nothing.
- R10: After both flags are low again, protection lasts `RECOV_CYC` more clocks. `rdata_oe` is 0 at edge 3+`RECOV_CYC` and 1 at edge 4+`RECOV_CYC` when a read is held.
- R11: If `pf_low` rises again during recovery, the guard goes straight back to protection, and the next recovery runs its full length.
- R12: `so_low` high in operational state protects immediately with no grace window. `rdata_oe` drops at edge 4 after `so_low` rises, and recovery waits for `so_low` to clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read (output) enable, active low |
| wr_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write byte |
| pf_low | input | 1 | Supply below power-fail threshold |
| so_low | input | 1 | Supply below battery-switchover threshold |
| rdata | output | DATA_W | Read byte |
| rdata_oe | output | 1 | Output enable for the tri-state bus driver |

## Verification
The hardest case to reach from the ports is a write that straddles the moment the guard enters its grace window. It must be stored if it closes in time (R6), and dropped if it closes too late (R7) or opens after the window starts (R8). The stimulus reaches this case by placing the flag edge and the strobe edges at chosen negedge offsets, so that each one lands on a known side of the synchronizer delay. The result then shows up in a read after recovery. Grace and recovery lengths are measured edge by edge while a read is held, so a window off by one clock is caught.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_GRACE   = 2'd1,
    ST_PROTECT = 2'd2,
    ST_RECOVER = 2'd3
  } pfw_state_e;
endpackage

// File: rtl/pfw_sync.sv
module pfw_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfw_pwr_fsm.sv
module pfw_pwr_fsm
  import pfw_pkg::*;
#(
  parameter int GRACE_CYC = 6,
  parameter int RECOV_CYC = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pf_s,
  input  logic       so_s,
  output pfw_state_e st
);
  localparam int MAXC  = (GRACE_CYC > RECOV_CYC) ? GRACE_CYC : RECOV_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_NORMAL;
      cnt <= '0;
    end else begin
      case (st)
        ST_NORMAL: begin
          if (so_s) begin
            st <= ST_PROTECT;
          end else if (pf_s) begin
            st  <= ST_GRACE;
            cnt <= CNT_W'(GRACE_CYC - 1);
          end
        end
        ST_GRACE: begin
          if (so_s || cnt == '0) st <= ST_PROTECT;
          else                   cnt <= cnt - 1'b1;
        end
        ST_PROTECT: begin
          if (!pf_s && !so_s) begin
            st  <= ST_RECOVER;
            cnt <= CNT_W'(RECOV_CYC - 1);
          end
        end
        default: begin
          if (pf_s || so_s)    st <= ST_PROTECT;
          else if (cnt == '0)  st <= ST_NORMAL;
          else                 cnt <= cnt - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pfw_access.sv
module pfw_access
  import pfw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              rd_s,
  input  logic              we_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] wdata_s,
  input  pfw_state_e        st,
  output logic              commit,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;
  logic              pend;
  logic              wr_open;
  logic              live;
  logic              rd_ok;

  assign wr_open = !cs_s && !we_s;
  assign live    = (st == ST_NORMAL) || (st == ST_GRACE);
  assign rd_ok   = !cs_s && !rd_s && we_s && live;
  assign commit  = pend && !wr_open && live;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd_ok;
      if (!live)                            pend <= 1'b0;
      else if (wr_open && st == ST_NORMAL)  pend <= 1'b1;
      else if (!wr_open)                    pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_open) begin
      wa_q <= addr_s;
      wd_q <= wdata_s;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[wa_q] <= wd_q;
    mem_q <= mem[addr_s];
  end

  assign rdata = mem_q;
endmodule

// File: rtl/pfw_sram_guard.sv
module pfw_sram_guard
  import pfw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int GRACE_CYC   = 6,
  parameter int RECOV_CYC   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pf_low,
  input  logic              so_low,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [4:0]        ctl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              cs_s, rd_s, we_s, pf_s, so_s;
  logic              commit;
  pfw_state_e        st;

  pfw_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync_ctl (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rd_n, wr_n, pf_low, so_low}),
    .q   (ctl_s)
  );

  pfw_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk (clk),
    .rst (rst),
    .d   ({addr, wdata}),
    .q   (bus_s)
  );

  assign {cs_s, rd_s, we_s, pf_s, so_s} = ctl_s;

  pfw_pwr_fsm #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk  (clk),
    .rst  (rst),
    .pf_s (pf_s),
    .so_s (so_s),
    .st   (st)
  );

  pfw_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .rd_s     (rd_s),
    .we_s     (we_s),
    .addr_s   (bus_s[BUS_W-1:DATA_W]),
    .wdata_s  (bus_s[DATA_W-1:0]),
    .st       (st),
    .commit   (commit),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );
endmodule

// File: rtl/pfw_guard_chk.sv
module pfw_guard_chk
  import pfw_pkg::*;
#(
  parameter int GRACE_CYC = 6,
  parameter int RECOV_CYC = 10
) (
  input logic       clk,
  input logic       rst,
  input pfw_state_e st,
  input logic       pf_s,
  input logic       so_s,
  input logic       we_s,
  input logic       commit,
  input logic       rdata_oe
);
  int unsigned gcnt, rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt <= 0;
      rcnt <= 0;
    end else begin
      gcnt <= (st == ST_GRACE)   ? gcnt + 1 : 0;
      rcnt <= (st == ST_RECOVER) ? rcnt + 1 : 0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !rdata_oe); // R1
  AST_WE_DROPS_OE: assert property (@(posedge clk) disable iff (rst) !we_s |=> !rdata_oe); // R4
  AST_GRACE_BOUND: assert property (@(posedge clk) disable iff (rst) (st == ST_GRACE) |-> (gcnt < GRACE_CYC)); // R5
  AST_NO_PROT_COMMIT: assert property (@(posedge clk) disable iff (rst) commit |-> (st == ST_NORMAL || st == ST_GRACE)); // R9
  AST_RECOV_FULL: assert property (@(posedge clk) disable iff (rst) (st == ST_NORMAL && $past(st) == ST_RECOVER) |-> (rcnt == RECOV_CYC)); // R10
  AST_REFAULT: assert property (@(posedge clk) disable iff (rst) (st == ST_RECOVER && (pf_s || so_s)) |=> (st == ST_PROTECT)); // R11
  AST_SO_NO_GRACE: assert property (@(posedge clk) disable iff (rst) (st == ST_NORMAL && so_s) |=> (st == ST_PROTECT)); // R12
endmodule

bind pfw_sram_guard pfw_guard_chk #(.GRACE_CYC(GRACE_CYC), .RECOV_CYC(RECOV_CYC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (st),
  .pf_s     (pf_s),
  .so_s     (so_s),
  .we_s     (we_s),
  .commit   (commit),
  .rdata_oe (rdata_oe)
);

// File: tb/test_pfw_sram_guard.sv
module test_pfw_sram_guard;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int G  = 6;
  localparam int RC = 10;
  localparam int NA = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          pf_low = 1'b0, so_low = 1'b0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pfw_sram_guard #(.ADDR_W(AW), .DATA_W(DW), .GRACE_CYC(G), .RECOV_CYC(RC)) i_pfw_sram_guard (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .pf_low(pf_low), .so_low(so_low),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 37 + 5 + s * 91) & 8'hFF);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    addr = AW'(a); wdata = d; cs_n = 0; wr_n = 0;
    tick(3);
    wr_n = 1; cs_n = 1;
    tick(3);
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] exp, input string req);
    addr = AW'(a); cs_n = 0; rd_n = 0;
    tick(4);
    chk(req, 32'(rdata_oe), 32'd1);
    chk(req, 32'(rdata), 32'(exp));
    cs_n = 1; rd_n = 1;
    tick(1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    tick(3);
    chk("R1", 32'(rdata_oe), 32'd0);
    rst = 0;
    tick(1);
    chk("R1", 32'(rdata_oe), 32'd0);

    // R2 R3: exhaustive fill and readback, two patterns
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < NA; a++) do_write(a, pat(a, s));
      for (int a = 0; a < NA; a++) do_read(a, pat(a, s), "R2");
    end

    // R3: wr_n falls first, cs_n closes the write, later bytes not stored
    addr = 4'd1; wdata = 8'hE1; wr_n = 0; tick(3);
    wdata = 8'h5A; cs_n = 0; tick(3);
    cs_n = 1; tick(3);
    wdata = 8'hC3; tick(3);
    wr_n = 1; tick(3);
    do_read(1, 8'h5A, "R3");

    // R4: write strobe during an enabled read drops the bus
    wdata = pat(2, 1); addr = 4'd2; cs_n = 0; rd_n = 0; tick(4);
    chk("R4", 32'(rdata_oe), 32'd1);
    wr_n = 0;
    tick(2); chk("R4", 32'(rdata_oe), 32'd1);
    tick(1); chk("R4", 32'(rdata_oe), 32'd0);
    wr_n = 1; cs_n = 1; rd_n = 1; tick(4);

    // R5 R10: measure grace and recovery edge by edge with a held read
    addr = 4'd3; cs_n = 0; rd_n = 0; tick(4);
    pf_low = 1;
    for (int k = 1; k <= G + 5; k++) begin
      tick(1);
      chk("R5", 32'(rdata_oe), (k <= 3 + G) ? 32'd1 : 32'd0);
    end
    pf_low = 0;
    for (int k = 1; k <= RC + 5; k++) begin
      tick(1);
      chk("R10", 32'(rdata_oe), (k >= 4 + RC) ? 32'd1 : 32'd0);
    end
    chk("R10", 32'(rdata), 32'(pat(3, 1)));
    cs_n = 1; rd_n = 1; tick(2);

    // R6: open write closes inside grace -> stored
    addr = 4'd5; wdata = 8'hA5; cs_n = 0; wr_n = 0; tick(1);
    pf_low = 1; tick(2);
    wr_n = 1; cs_n = 1; tick(G + 4);
    pf_low = 0; tick(RC + 5);
    do_read(5, 8'hA5, "R6");

    // R7: write still open at grace expiry -> aborted
    addr = 4'd6; wdata = 8'h3C; cs_n = 0; wr_n = 0; tick(1);
    pf_low = 1; tick(G + 6);
    wr_n = 1; cs_n = 1; tick(3);
    pf_low = 0; tick(RC + 5);
    do_read(6, pat(6, 1), "R7");

    // R8: write opened after grace began -> not stored
    pf_low = 1; tick(2);
    addr = 4'd7; wdata = 8'h11; cs_n = 0; wr_n = 0; tick(2);
    wr_n = 1; cs_n = 1; tick(G + 4);
    pf_low = 0; tick(RC + 5);
    do_read(7, pat(7, 1), "R8");

    // R9: strobes ignored while protected
    pf_low = 1; tick(G + 6);
    do_write(8, 8'h77);
    addr = 4'd8; cs_n = 0; rd_n = 0; tick(4);
    chk("R9", 32'(rdata_oe), 32'd0);
    cs_n = 1; rd_n = 1; tick(1);
    pf_low = 0; tick(RC + 5);
    do_read(8, pat(8, 1), "R9");

    // R11: flag returns during recovery -> full recovery again
    addr = 4'd9; cs_n = 0; rd_n = 0; tick(4);
    pf_low = 1; tick(G + 6);
    pf_low = 0; tick(5);
    pf_low = 1; tick(3);
    pf_low = 0;
    for (int k = 1; k <= RC + 5; k++) begin
      tick(1);
      chk("R11", 32'(rdata_oe), (k >= 4 + RC) ? 32'd1 : 32'd0);
    end
    chk("R11", 32'(rdata), 32'(pat(9, 1)));

    // R12: switchover flag protects without grace
    so_low = 1;
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      chk("R12", 32'(rdata_oe), (k <= 3) ? 32'd1 : 32'd0);
    end
    tick(10);
    so_low = 0;
    for (int k = 1; k <= RC + 5; k++) begin
      tick(1);
      chk("R12", 32'(rdata_oe), (k >= 4 + RC) ? 32'd1 : 32'd0);
    end
    cs_n = 1; rd_n = 1; tick(2);

    done = 1;
    finish_run();
  end
endmodule